// File: doc/BRIEF.md
# Memory Error Count Threshold Monitor

This block tallies memory-read error events and signals software once enough of them have built up. Two single-cycle pulse inputs carry events: one for correctable errors and one for uncorrectable errors. Both feed one shared 12-bit saturating tally. When an increment brings the tally to or above a programmable limit, a sticky overflow flag is set. An interrupt request follows that flag whenever the interrupt-enable bit is set.

A small register port gives access to the block. It has a write strobe, a 2-bit address, 12-bit write data and a combinational read-data output. Software reads the tally, clears it with any write, sets the interrupt and counting enables, and reads or writes the limit. Out of reset the interrupt is off, counting is on and the limit is at its maximum. The asynchronous reset is released synchronously inside the block.

Top module: `err_thresh_mon`

## Requirements
- R1: After reset the tally reads 0, the control register (address 1) reads 2 (interrupt enable bit 0 = 0, count enable bit 1 = 1), the limit (address 2) reads 0xFFF, and ovf and irq are low.
- R2: With counting enabled, each cycle adds one for a correctable pulse (evt_ce) and one for an uncorrectable pulse (evt_ue), so two when both are high, and the result is visible after that clock edge.
- R3: Reading address 0 returns the tally. Any write to address 0 clears the tally and the overflow flag, whatever the write data.
- R4: Control bit 1 enables counting. While it is 0, error pulses leave the tally unchanged.
- R5: Address 2 holds the 12-bit threshold limit, which is writable and reads back the value written.
- R6: When an increment makes the tally greater than or equal to the limit, ovf goes high after that edge. It stays high until the tally is cleared.
- R7: irq is high exactly while ovf is high and control bit 0 is 1. Clearing bit 0 drops irq and leaves ovf set.
- R8: The tally saturates at 4095 and never wraps.
- R9: When a clearing write and an error pulse fall in the same cycle, the clear wins and the tally becomes 0.
- R10: Address 3 reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_ce | input | 1 | Correctable error event pulse |
| evt_ue | input | 1 | Uncorrectable error event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 tally, 1 control, 2 limit) |
| bus_wdata | input | 12 | Register write data |
| bus_rdata | output | 12 | Register read data for bus_addr |
| ovf | output | 1 | Sticky threshold-reached flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a clearing write to the tally and an incoming error pulse. The bench provokes this by putting a write to address 0 and a correctable pulse on the same clock edge while the overflow flag is set. It then expects a tally of 0 with ovf and irq low, because a missed clear would leave 1 or the old value. A second collision, both error pulses in one cycle, must add two to the tally, and the bench checks that this crosses the limit within that same cycle.

// File: rtl/err_thresh_pkg.sv
package err_thresh_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_TALLY = 2'd0,
    REG_CTRL  = 2'd1,
    REG_LIMIT = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_IEN_BIT = 0;
  localparam int unsigned CTRL_CEN_BIT = 1;
endpackage

// File: rtl/err_thresh_rst_sync.sv
module err_thresh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/err_thresh_ctr.sv
module err_thresh_ctr #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         clr,
  input  logic         evt_ce,
  input  logic         evt_ue,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         bump
);
  localparam logic [W:0] SAT_MAX = {1'b0, {W{1'b1}}};

  logic [1:0]   add_amt;
  logic [W:0]   sum;
  logic [W-1:0] sat_sum;
  logic         load;

  always_comb begin
    add_amt = {1'b0, evt_ce} + {1'b0, evt_ue};
    sum     = {1'b0, cnt_q} + {{(W-1){1'b0}}, add_amt};
    sat_sum = (sum > SAT_MAX) ? SAT_MAX[W-1:0] : sum[W-1:0];
    bump    = cnt_en && (evt_ce || evt_ue) && !clr;
    load    = clr || bump;
    if (clr)       cnt_d = '0;
    else if (bump) cnt_d = sat_sum;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/err_thresh_cfg.sv
module err_thresh_cfg
  import err_thresh_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic              ien,
  output logic              cnt_en,
  output logic [W-1:0]      limit,
  output logic              clr
);
  logic         ctrl_we;
  logic         limit_we;
  logic         ien_d;
  logic         cen_d;
  logic [W-1:0] limit_d;

  always_comb begin
    clr      = wr && (addr == REG_TALLY);
    ctrl_we  = wr && (addr == REG_CTRL);
    limit_we = wr && (addr == REG_LIMIT);
    ien_d    = wdata[CTRL_IEN_BIT];
    cen_d    = wdata[CTRL_CEN_BIT];
    limit_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien    <= 1'b0;
      cnt_en <= 1'b1;
    end else if (ctrl_we) begin
      ien    <= ien_d;
      cnt_en <= cen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit <= '1;
    else if (limit_we) limit <= limit_d;
  end
endmodule

// File: rtl/err_thresh_flag.sv
module err_thresh_flag #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bump,
  input  logic [W-1:0] cnt_d,
  input  logic [W-1:0] limit,
  input  logic         ien,
  output logic         ovf,
  output logic         irq
);
  logic hit;
  logic ovf_en;
  logic ovf_d;

  always_comb begin
    hit    = bump && (cnt_d >= limit);
    ovf_en = clr || hit;
    ovf_d  = !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf <= 1'b0;
    else if (ovf_en) ovf <= ovf_d;
  end

  assign irq = ovf && ien;
endmodule

// File: rtl/err_thresh_mon.sv
module err_thresh_mon
  import err_thresh_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_ce,
  input  logic              evt_ue,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              ovf,
  output logic              irq
);
  logic             rst_n_i;
  logic             ien_w;
  logic             cen_w;
  logic             clr_w;
  logic             bump_w;
  logic [CNT_W-1:0] limit_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_next_w;

  err_thresh_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  err_thresh_cfg #(.W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .ien(ien_w), .cnt_en(cen_w), .limit(limit_w),
    .clr(clr_w)
  );

  err_thresh_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_i), .cnt_en(cen_w), .clr(clr_w),
    .evt_ce(evt_ce), .evt_ue(evt_ue), .cnt_q(cnt_w), .cnt_d(cnt_next_w),
    .bump(bump_w)
  );

  err_thresh_flag #(.W(CNT_W)) u_flag (
    .clk(clk), .rst_n(rst_n_i), .clr(clr_w), .bump(bump_w),
    .cnt_d(cnt_next_w), .limit(limit_w), .ien(ien_w), .ovf(ovf), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_TALLY: bus_rdata = cnt_w;
      REG_CTRL: begin
        bus_rdata[CTRL_IEN_BIT] = ien_w;
        bus_rdata[CTRL_CEN_BIT] = cen_w;
      end
      REG_LIMIT: bus_rdata = limit_w;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/err_thresh_mon_chk.sv
module err_thresh_mon_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         cnt_en,
  input logic         ien,
  input logic         evt_ce,
  input logic         evt_ue,
  input logic [W-1:0] cnt,
  input logic         ovf,
  input logic         irq
);
  localparam logic [W-1:0] CNT_MAX = '1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && !ovf); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (evt_ce || evt_ue)) |=> (cnt == '0)); // R9
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq); // R7
  AST_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt)); // R4
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (({1'b0, cnt} >= {1'b0, $past(cnt)}) &&
              ({1'b0, cnt} <= {1'b0, $past(cnt)} + 2))); // R2
endmodule

bind err_thresh_mon err_thresh_mon_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr_w), .cnt_en(cen_w), .ien(ien_w),
  .evt_ce(evt_ce), .evt_ue(evt_ue), .cnt(cnt_w), .ovf(ovf), .irq(irq)
);

// File: tb/err_thresh_mon_bench.sv
`timescale 1ns/1ps
module err_thresh_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_ce, evt_ue, bus_wr;
  logic [1:0]  bus_addr;
  logic [11:0] bus_wdata;
  logic [11:0] bus_rdata;
  logic        ovf, irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  err_thresh_mon u_err_thresh_mon (
    .clk(clk), .rst_n(rst_n), .evt_ce(evt_ce), .evt_ue(evt_ue),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf(ovf), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  a;
    logic [11:0] d;
    logic        ce;
    logic        ue;
    logic [11:0] cnt;
    logic        ovf;
    logic        irq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 12'h003, 1'b0, 1'b0, 12'd0, 1'b0, 1'b0}, // R5 limit 3
    '{1'b1, 2'd1, 12'h003, 1'b0, 1'b0, 12'd0, 1'b0, 1'b0}, // ien on
    '{1'b0, 2'd0, 12'h000, 1'b1, 1'b0, 12'd1, 1'b0, 1'b0}, // R2 ce
    '{1'b0, 2'd0, 12'h000, 1'b0, 1'b1, 12'd2, 1'b0, 1'b0}, // R2 ue
    '{1'b0, 2'd0, 12'h000, 1'b1, 1'b1, 12'd4, 1'b1, 1'b1}, // R2 R6 both
    '{1'b0, 2'd0, 12'h000, 1'b1, 1'b0, 12'd5, 1'b1, 1'b1}, // R6 sticky
    '{1'b1, 2'd1, 12'h002, 1'b0, 1'b0, 12'd5, 1'b1, 1'b0}, // R7 ien off
    '{1'b1, 2'd0, 12'h5A5, 1'b1, 1'b0, 12'd0, 1'b0, 1'b0}, // R9 R3
    '{1'b1, 2'd1, 12'h000, 1'b0, 1'b0, 12'd0, 1'b0, 1'b0}, // count off
    '{1'b0, 2'd0, 12'h000, 1'b1, 1'b1, 12'd0, 1'b0, 1'b0}, // R4 ignored
    '{1'b1, 2'd3, 12'hFFF, 1'b0, 1'b0, 12'd0, 1'b0, 1'b0}, // R10
    '{1'b1, 2'd1, 12'h003, 1'b0, 1'b0, 12'd0, 1'b0, 1'b0}, // both on
    '{1'b0, 2'd0, 12'h000, 1'b0, 1'b1, 12'd1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 12'h000, 1'b0, 1'b1, 12'd2, 1'b0, 1'b0},
    '{1'b0, 2'd0, 12'h000, 1'b0, 1'b1, 12'd3, 1'b1, 1'b1}, // R6 equal
    '{1'b1, 2'd0, 12'h000, 1'b0, 1'b0, 12'd0, 1'b0, 1'b0}  // R3 clear
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [11:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic step(input logic wr, input logic [1:0] a,
                      input logic [11:0] d, input logic ce, input logic ue);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_ce = ce; evt_ue = ue;
    @(posedge clk);
    #2;
    bus_wr = 1'b0; evt_ce = 1'b0; evt_ue = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    rst_n = 1'b0; evt_ce = 0; evt_ue = 0; bus_wr = 0; bus_addr = 0;
    bus_wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    read_reg(2'd0, v); check("R1 tally", v, 0);
    read_reg(2'd1, v); check("R1 ctrl", v, 2);
    read_reg(2'd2, v); check("R1 limit", v, 12'hFFF);
    check("R1 ovf", ovf, 0);
    check("R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].a, VEC[i].d, VEC[i].ce, VEC[i].ue);
      read_reg(2'd0, v);
      check($sformatf("vec%0d tally", i), v, VEC[i].cnt);
      check($sformatf("vec%0d ovf", i), ovf, VEC[i].ovf);
      check($sformatf("vec%0d irq", i), irq, VEC[i].irq);
    end

    read_reg(2'd2, v); check("R5 limit readback", v, 12'h003);
    read_reg(2'd3, v); check("R10 addr3 reads zero", v, 0);
    read_reg(2'd1, v); check("R4 ctrl readback", v, 3);

    // R8 saturation with limit at maximum
    step(1'b1, 2'd2, 12'hFFF, 1'b0, 1'b0);
    step(1'b1, 2'd0, 12'h000, 1'b0, 1'b0);
    @(negedge clk);
    evt_ce = 1'b1; evt_ue = 1'b1;
    repeat (2050) @(posedge clk);
    #2 evt_ce = 1'b0; evt_ue = 1'b0;
    read_reg(2'd0, v); check("R8 saturated", v, 12'hFFF);
    check("R6 ovf at max", ovf, 1);
    check("R7 irq at max", irq, 1);
    step(1'b0, 2'd0, 12'h000, 1'b1, 1'b0);
    read_reg(2'd0, v); check("R8 no wrap", v, 12'hFFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule